// File: doc/BRIEF.md
# Graded-Section Carry-Select Adder

This block adds two 32-bit operands and a carry-in, producing a 32-bit sum and a carry-out, with no clock and no state. The operand bits are cut into consecutive sections, each one a short ripple-carry chain of full adders. The least significant section is computed a single time from the true carry-in. Every section above it is computed twice at once, once with its carry-in tied low and once tied high. The genuine carry leaving the section below then picks one of the two trial results, both its sum bits and its carry-out, through a 2-to-1 multiplexer. The picked carry-out in turn becomes the select for the next section up.

Section widths come from a parameter list that must add up to the operand width. They grow toward the high-order end, so that a section's trial results settle at about the moment its select carry arrives. The default partition, from least to most significant, is 4, 4, 5, 6, 6, 7 bits. The section boundaries therefore fall at bit positions 4, 8, 13, 19 and 25. A datapath instantiates the block wherever a fast word-wide addition is needed.

Top module: `carry_select_adder`

## Requirements
- R1: For every input combination, {carry_out, sum} equals the 33-bit value of op_a + op_b + carry_in.
- R2: The default section widths, least significant first, are 4, 4, 5, 6, 6, 7. The carry entering each section boundary (bit 4, 8, 13, 19, 25) equals the true carry out of all lower bits.
- R3: The lowest section uses the real carry_in. With both operands zero and carry_in = 1, the sum is 1 and carry_out is 0.
- R4: The result of each upper section is the trial copy whose assumed carry-in matches the carry arriving from below. A carry generated in the top bit of one section and propagated through the whole next section yields the correct sum bits and carry.
- R5: For the longest carry path the results are as follows. op_a all ones with op_b = 1 and carry_in = 0 gives sum 0 and carry_out 1. op_a all ones with op_b = 0 and carry_in = 1 gives the same result. op_a all ones with op_b = 1 and carry_in = 1 gives sum 1 and carry_out 1.
- R6: All-zero inputs give sum 0 and carry_out 0. All-ones operands with carry_in = 1 give sum all ones and carry_out 1.
- R7: The outputs depend only on the present inputs. Reapplying an earlier input vector after different vectors reproduces the earlier result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 32 | Low 32 bits of op_a + op_b + carry_in |
| carry_out | output | 1 | Carry out of bit 31 |

## Verification
The assertions evaluate the combinational outputs and the internal section carries only while all three inputs carry known 0/1 values. Any X or Z on an operand skips the comparison. The bench drives every input bit from the first vector onward and changes inputs only on the falling edge of its sampling clock. It then looks at the outputs one nanosecond later, so the checker never sees a half-applied vector.

// File: rtl/csa_pkg.sv
// Package: shared constants for the graded carry-select adder.
// Assumes the section list sums to CSA_WIDTH; index 0 is least significant.
package csa_pkg;
    localparam int unsigned CSA_WIDTH = 32;
    localparam int unsigned CSA_NSECT = 6;
    localparam int unsigned CSA_DEF_W [CSA_NSECT] = '{4, 4, 5, 6, 6, 7};
endpackage

// File: rtl/csa_full_adder.sv
// Module: one-bit full adder, sum and carry from two bits and a carry-in.
// Assumes nothing beyond known input values.
module csa_full_adder (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    logic half;

    // Form the half-sum, final sum and carry.
    always_comb begin
        half = x ^ y;
        s    = half ^ ci;
        co   = (x & y) | (ci & half);
    end
endmodule

// File: rtl/csa_ripple.sv
// Module: W-bit ripple-carry chain built from full adders.
// Assumes W >= 1; carry passes from bit i to bit i+1.
module csa_ripple #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] chain;

    assign chain[0] = ci;
    assign co       = chain[W];

    // One full adder per bit, carry linked in a chain.
    for (genvar i = 0; i < W; i++) begin : g_bit
        csa_full_adder u_fa (
            .x  (x[i]),
            .y  (y[i]),
            .ci (chain[i]),
            .s  (s[i]),
            .co (chain[i+1])
        );
    end
endmodule

// File: rtl/csa_section.sv
// Module: one adder section. With DUAL = 0 it ripples from the real carry.
// With DUAL = 1 it computes trial sums for carry 0 and 1 and selects with sel.
// Assumes sel is the genuine carry out of the section below.
module csa_section #(
    parameter int unsigned W    = 4,
    parameter bit          DUAL = 1'b1
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sel,
    output logic [W-1:0] s,
    output logic         co
);
    if (DUAL) begin : g_dual
        logic [W-1:0] s_lo, s_hi;
        logic         co_lo, co_hi;

        csa_ripple #(.W(W)) u_trial0 (
            .x (x), .y (y), .ci (1'b0), .s (s_lo), .co (co_lo)
        );
        csa_ripple #(.W(W)) u_trial1 (
            .x (x), .y (y), .ci (1'b1), .s (s_hi), .co (co_hi)
        );

        // Pick the trial whose assumed carry matches the arriving carry.
        always_comb begin
            if (sel) begin
                s  = s_hi;
                co = co_hi;
            end else begin
                s  = s_lo;
                co = co_lo;
            end
        end
    end else begin : g_single
        csa_ripple #(.W(W)) u_base (
            .x (x), .y (y), .ci (sel), .s (s), .co (co)
        );
    end
endmodule

// File: rtl/carry_select_adder.sv
// Module: graded-section carry-select adder (top).
// Splits the operands into NUM_SECT sections of widths SECT_W (index 0 lowest).
// Assumes the widths sum to WIDTH. Purely combinational.
module carry_select_adder #(
    parameter int unsigned WIDTH    = csa_pkg::CSA_WIDTH,
    parameter int unsigned NUM_SECT = csa_pkg::CSA_NSECT,
    parameter int unsigned SECT_W [NUM_SECT] = csa_pkg::CSA_DEF_W
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    // Lowest bit position of section k.
    function automatic int unsigned base_of(input int unsigned k);
        int unsigned acc;
        acc = 0;
        for (int unsigned j = 0; j < k; j++) acc += SECT_W[j];
        return acc;
    endfunction

    logic [NUM_SECT:0] sec_carry;

    assign sec_carry[0] = carry_in;
    assign carry_out    = sec_carry[NUM_SECT];

    // One section per list entry; only the lowest is single-copy.
    for (genvar k = 0; k < NUM_SECT; k++) begin : g_sect
        localparam int unsigned LO = base_of(k);
        localparam int unsigned SW = SECT_W[k];

        csa_section #(.W(SW), .DUAL(k != 0)) u_sect (
            .x   (op_a[LO +: SW]),
            .y   (op_b[LO +: SW]),
            .sel (sec_carry[k]),
            .s   (sum[LO +: SW]),
            .co  (sec_carry[k+1])
        );
    end
endmodule

// File: rtl/csa_checker.sv
// Module: assertion checker bound to carry_select_adder.
// Assumes inputs are known; checks are skipped while any input is X/Z.
module csa_checker #(
    parameter int unsigned WIDTH    = 32,
    parameter int unsigned NUM_SECT = 6,
    parameter int unsigned SECT_W [NUM_SECT] = '{4, 4, 5, 6, 6, 7}
) (
    input logic [WIDTH-1:0]  op_a,
    input logic [WIDTH-1:0]  op_b,
    input logic              carry_in,
    input logic [WIDTH-1:0]  sum,
    input logic              carry_out,
    input logic [NUM_SECT:0] sec_carry
);
    function automatic int unsigned edge_of(input int unsigned k);
        int unsigned acc;
        acc = 0;
        for (int unsigned j = 0; j < k; j++) acc += SECT_W[j];
        return acc;
    endfunction

    logic [WIDTH:0] full_ref;
    logic           known;

    // Reference sum and input validity.
    always_comb begin
        full_ref = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
        known    = !$isunknown({op_a, op_b, carry_in});
    end

    // R1: whole result matches the arithmetic sum.
    always_comb begin
        if (known)
            a_r1_exact_sum: assert ({carry_out, sum} == full_ref);
    end

    // R2 / R4: carry at every section boundary equals the true lower carry.
    always_comb begin
        for (int unsigned k = 1; k <= NUM_SECT; k++) begin
            logic [WIDTH:0] mask, part;
            int unsigned    p;
            p    = edge_of(k);
            mask = ({{WIDTH{1'b0}}, 1'b1} << p) - 1'b1;
            part = ({1'b0, op_a} & mask) + ({1'b0, op_b} & mask)
                 + {{WIDTH{1'b0}}, carry_in};
            if (known)
                a_r4_boundary_carry: assert (sec_carry[k] == part[p]);
        end
    end

    // R3: lowest section sees the real carry-in.
    always_comb begin
        if (known && op_a == '0 && op_b == '0)
            a_r3_base_carry: assert (sum == {{(WIDTH-1){1'b0}}, carry_in} && !carry_out);
    end

    // R5: longest chain, all ones plus one.
    always_comb begin
        if (known && op_a == '1 && op_b == {{(WIDTH-1){1'b0}}, 1'b1} && !carry_in)
            a_r5_long_chain: assert (sum == '0 && carry_out);
    end
endmodule

bind carry_select_adder csa_checker #(
    .WIDTH(WIDTH), .NUM_SECT(NUM_SECT), .SECT_W(SECT_W)
) u_csa_checker (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum(sum), .carry_out(carry_out), .sec_carry(sec_carry)
);

// File: tb/test_carry_select_adder.sv
// Bench: directed tasks per scenario, plus random vectors, against a + b + c.
module test_carry_select_adder;
    logic        clk;
    logic [31:0] op_a, op_b, sum;
    logic        carry_in, carry_out;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 0;

    carry_select_adder i_carry_select_adder (
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .sum(sum), .carry_out(carry_out)
    );

    // 200 MHz sampling clock.
    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Drive on falling edge, sample 1 ns later, compare with reference.
    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic c, input string req);
        logic [32:0] exp;
        @(negedge clk);
        op_a = a; op_b = b; carry_in = c;
        #1;
        exp = {1'b0, a} + {1'b0, b} + {32'd0, c};
        n_checks++;
        if ({carry_out, sum} !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h c=%0d got=%h exp=%h",
                     req, a, b, c, {carry_out, sum}, exp);
        end
    endtask

    // R6: all-zero and all-one operands.
    task automatic t_extremes();
        apply(32'h0, 32'h0, 1'b0, "R6 zeros");
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R6 ones c1");
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R6 ones c0");
    endtask

    // R3: carry-in alone reaches the lowest section.
    task automatic t_base_carry();
        apply(32'h0, 32'h0, 1'b1, "R3 cin only");
        apply(32'h0000_000F, 32'h0, 1'b1, "R3 low section overflow");
    endtask

    // R5: longest carry path with both carry-in values.
    task automatic t_long_chain();
        apply(32'hFFFF_FFFF, 32'h1, 1'b0, "R5 ones+1");
        apply(32'hFFFF_FFFF, 32'h0, 1'b1, "R5 ones+cin");
        apply(32'hFFFF_FFFF, 32'h1, 1'b1, "R5 ones+1+cin");
    endtask

    // R2 / R4: carries crossing each boundary at bits 4, 8, 13, 19, 25.
    task automatic t_boundaries();
        int unsigned edges [5] = '{4, 8, 13, 19, 25};
        for (int i = 0; i < 5; i++) begin
            logic [31:0] below, span;
            below = (32'd1 << edges[i]) - 32'd1;
            apply(below, 32'd1, 1'b0, "R2 ripple to boundary");
            apply(below, 32'd0, 1'b1, "R2 cin to boundary");
            span = (i < 4) ? ((32'd1 << edges[i+1]) - 32'd1) : 32'hFFFF_FFFF;
            span = span & ~((32'd1 << (edges[i] - 1)) - 32'd1);
            apply(span, 32'd1 << (edges[i] - 1), 1'b0, "R4 generate then propagate");
            apply(32'd1 << edges[i], 32'd1 << edges[i], 1'b0, "R4 no incoming carry");
        end
    endtask

    // R7: same vector after other traffic gives the same result.
    task automatic t_history();
        apply(32'h1234_5678, 32'h8765_4321, 1'b1, "R7 first");
        apply(32'hFFFF_FFFF, 32'h1, 1'b1, "R7 other");
        apply(32'h1234_5678, 32'h8765_4321, 1'b1, "R7 repeat");
    endtask

    // R1: random operands and carry-in.
    task automatic t_random();
        for (int i = 0; i < 4000; i++)
            apply($urandom, $urandom, 1'($urandom), "R1 random");
    endtask

    initial begin
        op_a = '0; op_b = '0; carry_in = 1'b0;
        t_extremes();
        t_base_carry();
        t_long_chain();
        t_boundaries();
        t_history();
        t_random();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired got=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule